// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock for an SD host from its base clock. The total ratio is the product of two stages: a prescaler whose code is a one-hot power of two, and a linear divisor from 1 to 16. In double-data-rate mode the prescaler moves up one power of two, so software writes the single-rate code shifted right by one. The card clock comes out of a register in the base clock domain. It is free of glitches, and a new ratio takes effect only where one card clock period ends and the next begins.

A single control word holds the internal clock enable, the card clock gate, the two divider fields and a request bit for the power-up burst. Reads return the same word with a status bit for stable and a busy view of the burst. After the internal clock is enabled, and after every accepted change of a divider field, the stable bit stays low for a fixed settle time. Divider fields and the card gate are accepted only while stable is high. Setting the burst bit produces exactly 80 card clocks, even with the card gate off, and the bit then clears itself. The ratio mode is a plain input pin. The block has no streaming data path, so it uses no valid/ready handshake.

Top module: `sdclk_divider`

## Requirements
- R1: After reset, rd_data reads all zero and card_clk is low.
- R2: Bit 0 enables the internal clock. Bit 1 (read-only) goes high exactly SETTLE (default 8) cycles after the write that sets bit 0 from 0. While bit 0 is clear, bit 1 reads 0 and card_clk stays low.
- R3: A write made while stable is high, whose prescaler field (bits 15:8) or divisor field (bits 7:4) differs from the stored value, takes the new values and holds stable low for exactly SETTLE cycles.
- R4: Writes to the divider fields while stable is low are ignored. The stored fields read back unchanged.
- R5: Bit 2 (card gate) can become 1 only by a write made while stable is high. Otherwise it reads 0 and card_clk stays low outside a burst.
- R6: In single-rate mode (ddr_mode=0), prescaler code 0 divides by 1, and a code whose highest set bit is k divides by 2^(k+1). A code with several bits set uses its highest bit.
- R7: In double-rate mode (ddr_mode=1) the prescaler divides by twice its single-rate value: code 0 gives 2 and code 0x80 gives 512.
- R8: The divisor field divides by its value plus 1. The total ratio N is prescaler times divisor, and a total of 1 is raised to 2.
- R9: With the gate on, card_clk has period N base cycles, high for floor(N/2) cycles and low for the rest. Each rising edge starts a period.
- R10: A new ratio or mode takes effect at the next period boundary. The period in progress completes at its old length.
- R11: Writing 1 to bit 27 while the internal clock is already enabled and no burst is running produces exactly 80 card_clk rising edges. Bit 27 reads 1 until the last of those periods ends, then reads 0. With the internal clock disabled the request is ignored and bit 27 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes wr_data into the control word this cycle |
| wr_data | input | 32 | Control word to write |
| ddr_mode | input | 1 | 1 selects the double-rate prescaler meaning |
| rd_data | output | 32 | Control word with stable (bit 1) and burst busy (bit 27) |
| card_clk | output | 1 | Divided card clock, registered |

## Verification
A wrong period counter or ratio latch shows up within one card period as a wrong high or low length on card_clk, so the bench measures both phases for each code pattern. If the ratio is reloaded at the wrong moment, the period during which the write lands comes out at the wrong length. A settle counter that is off by one shows in the exact count of low cycles of the stable bit. A burst counter error shows after the burst as a wrong edge total, or as bit 27 staying set.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
  parameter int unsigned PRE_W_DEF = 8;
  parameter int unsigned DIV_W_DEF = 4;
  typedef enum logic {RATE_SDR = 1'b0, RATE_DDR = 1'b1} rate_mode_e;
endpackage

// File: rtl/sdclk_ratio.sv
`timescale 1ns/1ps
module sdclk_ratio #(
  parameter int PRE_W = sdclk_pkg::PRE_W_DEF,
  parameter int DIV_W = sdclk_pkg::DIV_W_DEF,
  parameter int N_W   = PRE_W + DIV_W + 2
) (
  input  logic [PRE_W-1:0] pre_code,
  input  logic [DIV_W-1:0] div_code,
  input  logic             ddr,
  output logic [N_W-1:0]   total
);
  localparam int EXP_W = $clog2(PRE_W + 2);

  logic [PRE_W-1:0] top_bit;
  logic [EXP_W-1:0] exp_sdr;
  logic [EXP_W-1:0] shift;
  logic [N_W-1:0]   base_div;
  logic [N_W-1:0]   raw;
  sdclk_pkg::rate_mode_e mode;

  // keep only the highest set bit of the prescaler code
  genvar i;
  generate
    for (i = 0; i < PRE_W; i++) begin : g_top
      if (i == PRE_W - 1) begin : g_msb
        assign top_bit[i] = pre_code[i];
      end else begin : g_low
        assign top_bit[i] = pre_code[i] & ~(|pre_code[PRE_W-1:i+1]);
      end
    end
  endgenerate

  always_comb begin
    exp_sdr = '0;
    for (int k = 0; k < PRE_W; k++) begin
      if (top_bit[k]) exp_sdr = EXP_W'(k + 1);
    end
  end

  assign mode     = sdclk_pkg::rate_mode_e'(ddr);
  assign shift    = exp_sdr + ((mode == sdclk_pkg::RATE_DDR) ? EXP_W'(1) : EXP_W'(0));
  assign base_div = N_W'(div_code) + N_W'(1);
  assign raw      = base_div << shift;
  assign total    = (raw < N_W'(2)) ? N_W'(2) : raw;
endmodule

// File: rtl/sdclk_ctrl.sv
`timescale 1ns/1ps
module sdclk_ctrl #(
  parameter int DATA_W  = 32,
  parameter int PRE_W   = sdclk_pkg::PRE_W_DEF,
  parameter int DIV_W   = sdclk_pkg::DIV_W_DEF,
  parameter int SETTLE  = 8,
  parameter int EN_BIT  = 0,
  parameter int CEN_BIT = 2,
  parameter int DIV_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              int_en,
  output logic              card_en,
  output logic [PRE_W-1:0]  pre_code,
  output logic [DIV_W-1:0]  div_code,
  output logic              stable
);
  localparam int PRE_LSB = DIV_LSB + DIV_W;
  localparam int ST_W    = $clog2(SETTLE + 1);

  logic             int_en_q, card_en_q;
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [ST_W-1:0]  settle_q;
  logic [PRE_W-1:0] new_pre;
  logic [DIV_W-1:0] new_div;
  logic             fld_change, en_rise;

  assign new_pre    = wr_data[PRE_LSB +: PRE_W];
  assign new_div    = wr_data[DIV_LSB +: DIV_W];
  assign stable     = int_en_q && (settle_q == '0);
  assign fld_change = wr_en && stable && ({new_pre, new_div} != {pre_q, div_q});
  assign en_rise    = wr_en && wr_data[EN_BIT] && !int_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q  <= 1'b0;
      card_en_q <= 1'b0;
      pre_q     <= '0;
      div_q     <= '0;
      settle_q  <= '0;
    end else begin
      if (wr_en) begin
        int_en_q  <= wr_data[EN_BIT];
        card_en_q <= wr_data[CEN_BIT] && wr_data[EN_BIT] && (stable || card_en_q);
      end
      if (fld_change) begin
        pre_q <= new_pre;
        div_q <= new_div;
      end
      if (en_rise || fld_change) settle_q <= ST_W'(SETTLE);
      else if (settle_q != '0)   settle_q <= settle_q - 1'b1;
    end
  end

  assign int_en   = int_en_q;
  assign card_en  = card_en_q;
  assign pre_code = pre_q;
  assign div_code = div_q;

  p_enable_settles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> !stable);
  p_change_drops_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fld_change |=> !stable);
  p_fields_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stable |=> $stable({pre_q, div_q}));
  p_gate_after_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_en_q) |-> $past(stable));
endmodule

// File: rtl/sdclk_wave.sv
`timescale 1ns/1ps
module sdclk_wave #(
  parameter int N_W       = 14,
  parameter int INIT_CLKS = 80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           card_en,
  input  logic           init_req,
  input  logic [N_W-1:0] total,
  output logic           card_clk,
  output logic           init_busy
);
  localparam int IC_W = $clog2(INIT_CLKS + 1);

  logic [N_W-1:0]  cnt_q, n_cur_q, cnt_nxt, half;
  logic            on_q, clk_q, burst_q, wrap, take_init, burst_due;
  logic [IC_W-1:0] left_q;

  assign wrap      = (cnt_q == n_cur_q - N_W'(1));
  assign cnt_nxt   = cnt_q + N_W'(1);
  assign half      = n_cur_q >> 1;
  assign burst_due = (left_q != '0);
  assign init_busy = burst_due || burst_q;
  assign take_init = init_req && run && !init_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      n_cur_q <= N_W'(2);
      on_q    <= 1'b0;
      clk_q   <= 1'b0;
      burst_q <= 1'b0;
      left_q  <= '0;
    end else if (!run) begin
      cnt_q   <= '0;
      n_cur_q <= total;
      on_q    <= 1'b0;
      clk_q   <= 1'b0;
      burst_q <= 1'b0;
      left_q  <= '0;
    end else begin
      if (wrap) begin
        cnt_q   <= '0;
        n_cur_q <= total;
        on_q    <= card_en || burst_due;
        clk_q   <= card_en || burst_due;
        burst_q <= burst_due;
        if (burst_due) left_q <= left_q - 1'b1;
      end else begin
        cnt_q <= cnt_nxt;
        clk_q <= on_q && (cnt_nxt < half);
      end
      if (take_init) left_q <= IC_W'(INIT_CLKS);
    end
  end

  assign card_clk = clk_q;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !clk_q);
  p_rise_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> $past(wrap));
  p_ratio_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> (!run || $stable(n_cur_q)));
  p_burst_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= IC_W'(INIT_CLKS));
endmodule

// File: rtl/sdclk_divider.sv
`timescale 1ns/1ps
module sdclk_divider #(
  parameter int DATA_W    = 32,
  parameter int PRE_W     = sdclk_pkg::PRE_W_DEF,
  parameter int DIV_W     = sdclk_pkg::DIV_W_DEF,
  parameter int SETTLE    = 8,
  parameter int INIT_CLKS = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ddr_mode,
  output logic [DATA_W-1:0] rd_data,
  output logic              card_clk
);
  localparam int EN_BIT   = 0;
  localparam int STB_BIT  = 1;
  localparam int CEN_BIT  = 2;
  localparam int DIV_LSB  = 4;
  localparam int PRE_LSB  = DIV_LSB + DIV_W;
  localparam int INIT_BIT = 27;
  localparam int N_W      = PRE_W + DIV_W + 2;

  logic             int_en, card_en, stable, init_busy;
  logic [PRE_W-1:0] pre_code;
  logic [DIV_W-1:0] div_code;
  logic [N_W-1:0]   total;

  sdclk_ctrl #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .DIV_W(DIV_W), .SETTLE(SETTLE),
    .EN_BIT(EN_BIT), .CEN_BIT(CEN_BIT), .DIV_LSB(DIV_LSB)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .int_en(int_en), .card_en(card_en), .pre_code(pre_code),
    .div_code(div_code), .stable(stable)
  );

  sdclk_ratio #(.PRE_W(PRE_W), .DIV_W(DIV_W), .N_W(N_W)) u_ratio (
    .pre_code(pre_code), .div_code(div_code), .ddr(ddr_mode), .total(total)
  );

  sdclk_wave #(.N_W(N_W), .INIT_CLKS(INIT_CLKS)) u_wave (
    .clk(clk), .rst_n(rst_n), .run(int_en), .card_en(card_en),
    .init_req(wr_en && wr_data[INIT_BIT]), .total(total),
    .card_clk(card_clk), .init_busy(init_busy)
  );

  always_comb begin
    rd_data                    = '0;
    rd_data[EN_BIT]            = int_en;
    rd_data[STB_BIT]           = stable;
    rd_data[CEN_BIT]           = card_en;
    rd_data[DIV_LSB +: DIV_W]  = div_code;
    rd_data[PRE_LSB +: PRE_W]  = pre_code;
    rd_data[INIT_BIT]          = init_busy;
  end
endmodule

// File: tb/sdclk_divider_bench.sv
`timescale 1ns/1ps
module sdclk_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        ddr_mode = 1'b0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  wire         card_clk;

  localparam int SETTLE = 8;
  localparam int NVEC   = 12;
  // {pre[47:40], div[39:36], ddr[35:32], high[31:16], low[15:0]}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'h00, 4'h0, 4'h0, 16'd1,    16'd1},
    {8'h00, 4'h3, 4'h0, 16'd2,    16'd2},
    {8'h01, 4'h0, 4'h0, 16'd1,    16'd1},
    {8'h04, 4'h2, 4'h0, 16'd12,   16'd12},
    {8'h02, 4'h4, 4'h0, 16'd10,   16'd10},
    {8'h00, 4'h2, 4'h0, 16'd1,    16'd2},
    {8'h06, 4'h0, 4'h0, 16'd4,    16'd4},
    {8'h00, 4'h0, 4'h1, 16'd1,    16'd1},
    {8'h01, 4'h1, 4'h1, 16'd4,    16'd4},
    {8'h80, 4'h0, 4'h1, 16'd256,  16'd256},
    {8'h80, 4'hF, 4'h0, 16'd2048, 16'd2048},
    {8'h00, 4'hE, 4'h0, 16'd7,    16'd8}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sdclk_divider u_sdclk_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ddr_mode(ddr_mode), .rd_data(rd_data), .card_clk(card_clk)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(input logic [7:0] p, input logic [3:0] d,
                                      input bit cen, input bit en);
    cfg = {16'h0, p, d, 1'b0, cen, 1'b0, en};
  endfunction

  // called at a falling edge; captured at the following rising edge
  task automatic wr(input logic [31:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_stable(output int lows);
    lows = 0;
    while (!rd_data[1] && lows < 1000) begin
      @(negedge clk);
      lows++;
    end
  endtask

  task automatic wait_rise();
    int n = 0;
    bit p = card_clk;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (card_clk && !p) break;
      p = card_clk;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise();
    hi = 0;
    lo = 0;
    while (card_clk && hi < 20000) begin hi++; @(negedge clk); end
    while (!card_clk && lo < 20000) begin lo++; @(negedge clk); end
  endtask

  task automatic count_rises(input int cycles, output int rises);
    bit p = card_clk;
    rises = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (card_clk && !p) rises++;
      p = card_clk;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int lows, hi, lo, r, c;
    bit p;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 32'h0, "R1 reset rd_data", int'(rd_data), 0);
    chk(card_clk == 1'b0, "R1 reset card_clk", int'(card_clk), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 gate refused with internal clock off
    wr(32'h0000_0004);
    chk(rd_data[2] == 1'b0, "R5 gate while disabled", int'(rd_data[2]), 0);
    count_rises(20, r);
    chk(r == 0, "R5 no card clock while gate refused", r, 0);

    // R11 burst ignored while disabled
    wr(32'h0800_0000);
    chk(rd_data[27] == 1'b0, "R11 burst ignored when disabled", int'(rd_data[27]), 0);
    count_rises(20, r);
    chk(r == 0, "R11 no edges when disabled", r, 0);

    // R2 enable and settle time
    wr(cfg(8'h00, 4'h0, 0, 1));
    chk(rd_data[1] == 1'b0, "R2 stable low right after enable", int'(rd_data[1]), 0);
    wait_stable(lows);
    chk(lows == SETTLE, "R2 settle after enable", lows, SETTLE);

    // R3 field change drops stable for SETTLE cycles
    wr(cfg(8'h00, 4'h3, 0, 1));
    wait_stable(lows);
    chk(lows == SETTLE, "R3 settle after field change", lows, SETTLE);
    chk(rd_data[7:4] == 4'h3, "R3 divisor taken", int'(rd_data[7:4]), 3);

    // R4 and R5: writes during settle ignored
    wr(cfg(8'h00, 4'h5, 0, 1));
    wr(cfg(8'h02, 4'h7, 1, 1));
    wait_stable(lows);
    chk(rd_data[7:4] == 4'h5, "R4 divisor write during settle", int'(rd_data[7:4]), 5);
    chk(rd_data[15:8] == 8'h00, "R4 prescaler write during settle", int'(rd_data[15:8]), 0);
    chk(rd_data[2] == 1'b0, "R5 gate write during settle", int'(rd_data[2]), 0);

    // R6 R7 R8 R9 ratio and waveform table
    for (int i = 0; i < NVEC; i++) begin
      ddr_mode = (VEC[i][35:32] != 4'h0);
      wr(cfg(VEC[i][47:40], VEC[i][39:36], 1, 1));
      wait_stable(lows);
      chk(rd_data[2] == 1'b1, "R5 gate accepted when stable", int'(rd_data[2]), 1);
      wait_rise();
      wait_rise();
      measure(hi, lo);
      chk(hi == int'(VEC[i][31:16]), "R9 high phase (R6 R7 R8 ratio)", hi, int'(VEC[i][31:16]));
      chk(lo == int'(VEC[i][15:0]), "R9 low phase (R6 R7 R8 ratio)", lo, int'(VEC[i][15:0]));
    end

    // R10 ratio switch only at a period boundary
    ddr_mode = 1'b0;
    wr(cfg(8'h04, 4'h2, 1, 1));
    wait_stable(lows);
    wait_rise();
    wait_rise();
    wait_rise();
    c = 0;
    repeat (3) begin @(negedge clk); c++; end
    wr(cfg(8'h00, 4'h3, 1, 1));
    c++;
    p = card_clk;
    while (c < 1000) begin
      @(negedge clk);
      c++;
      if (card_clk && !p) break;
      p = card_clk;
    end
    chk(c == 24, "R10 period in progress keeps old length", c, 24);
    measure(hi, lo);
    chk(hi + lo == 4, "R10 new ratio after boundary", hi + lo, 4);

    // R11 burst of 80 with the gate off
    wr(cfg(8'h00, 4'h3, 0, 1));
    wait_stable(lows);
    repeat (12) @(negedge clk);
    count_rises(40, r);
    chk(r == 0, "R5 gate off stops card clock", r, 0);
    wr(cfg(8'h00, 4'h3, 0, 1) | 32'h0800_0000);
    chk(rd_data[27] == 1'b1, "R11 burst bit set", int'(rd_data[27]), 1);
    count_rises(400, r);
    chk(r == 80, "R11 burst edge count", r, 80);
    chk(rd_data[27] == 1'b0, "R11 burst bit self-clears", int'(rd_data[27]), 0);

    // R2 disable stops everything
    wr(32'h0);
    chk(rd_data[1] == 1'b0, "R2 stable low when disabled", int'(rd_data[1]), 0);
    count_rises(20, r);
    chk(r == 0, "R2 no card clock when disabled", r, 0);

    finish_run();
  end
endmodule